// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a program sequencer and presents one vectored request at a time. It has three external request pins, which are active low and can each be set to edge or level sensing, and a parameterised set of internal level requests. The internal requests come from the timer, the serial port transmit and receive sides, and the host port read and write sides. A reset request sits above all of them and cannot be masked.

Each cycle the controller qualifies every request against a mask word and keeps the candidates that the current service state allows. It then picks the one with the lowest index and registers its index and vector address. The sequencer takes the request with an acknowledge pulse and ends the service with a return pulse. A mode input chooses between two service styles. In nested mode, active service levels are kept on a stack, so a higher priority request can preempt the current one. In sequential mode, only one service can be active at a time.

Top module: `irq_vector_ctl`

## Requirements
- R1: After the synchronous reset `rst`, `irq_valid` is 0, `vec_idx` and `vec_addr` are 0, and no service is active.
- R2: Source indices run from 0 (highest priority) upward. Index 0 is the reset request. Index 1 is pin 2, index 2 is pin 1 and index 3 is pin 0. Index 4+k is `int_req[k]`. Among the eligible requests, the lowest index is presented.
- R3: For each index i ≥ 1, the request at index i is taken only when `mask[i-1]` is 1. A 0 in that bit blocks it.
- R4: The reset request (index 0) ignores the mask. In both modes it is taken whenever reset is not itself the active service level.
- R5: `vec_addr` equals four times `vec_idx`. The outputs are registered: a level request is shown one clock edge after it is applied, and an edge request two edges after its falling edge.
- R6: A pin with its `edge_sel` bit at 0 requests only while it is held low. Once it is released, nothing is remembered.
- R7: A pin with its `edge_sel` bit at 1 latches a high-to-low transition. The latched request stays pending after the pin rises, until that index is acknowledged.
- R8: `ack` is accepted only in a cycle where `irq_valid` is 1, and `irq_valid` is 0 in the cycle after an accepted acknowledge. An `ack` while `irq_valid` is 0 changes no state.
- R9: With `nest_mode` at 1, an acknowledge pushes the index onto the active-level stack and `rti` pops it. In this mode, only a request with an index strictly lower than the top of the stack is eligible.
- R10: With `nest_mode` at 0, no request other than reset is eligible while any service is active.
- R11: `rti` while no service is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Non-maskable reset request, index 0 |
| pin_n | input | NUM_PINS | External request pins, active low |
| edge_sel | input | NUM_PINS | Per-pin sensing, 1 = falling edge, 0 = low level |
| int_req | input | NUM_INT | Internal level requests, active high |
| mask | input | NUM_SRC-1 | Enable per maskable index, bit i-1 for index i |
| nest_mode | input | 1 | 1 = nested preemption, 0 = one service at a time |
| ack | input | 1 | Sequencer takes the presented request |
| rti | input | 1 | Sequencer ends the current service |
| irq_valid | output | 1 | A vectored request is presented |
| vec_idx | output | IDX_W | Priority index of the presented request |
| vec_addr | output | ADDR_W | Vector address, four words per index |

## Verification
Some behaviours are checked by assertions on every cycle. A presented non-reset index must have had its mask bit set. The request line must drop right after an accepted acknowledge. The stack must never grow past its depth, and every push onto a non-empty stack must carry a strictly higher priority than the current top.

Other behaviours appear only in the bench's scenarios. These include the priority order among mixed sources, edge latching compared with level following, preemption and its refusal in each mode, reset still being taken when masked or when a service is active, and the level restored after a return.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  // External request pins handled by the sense stage
  localparam int NUM_PINS  = 3;
  // Vector slots are four words apart: address = index << VEC_SHIFT
  localparam int VEC_SHIFT = 2;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic [NUM_PINS-1:0] edge_sel,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] pend
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] latch_q;

  for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
    logic fall;
    assign fall = prev_q[j] & ~pin_n[j];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[j]  <= 1'b1;
        latch_q[j] <= 1'b0;
      end else begin
        prev_q[j] <= pin_n[j];
        if (edge_sel[j] && fall)
          latch_q[j] <= 1'b1;
        else if (clr[j] || !edge_sel[j])
          latch_q[j] <= 1'b0;
      end
    end

    assign pend[j] = edge_sel[j] ? latch_q[j] : ~pin_n[j];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH = 12,
  parameter int IDX_W = 4,
  parameter int IDLE  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             empty,
  output logic [IDX_W-1:0] top_idx
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;

  assign cnt_m1 = cnt - 1'b1;
  assign empty  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (push)
      cnt <= cnt + 1'b1;
    else if (pop && !empty)
      cnt <= cnt_m1;
  end

  // storage without reset so it maps to plain RAM/registers
  always_ff @(posedge clk) begin
    if (push)
      stk[cnt[PTR_W-1:0]] <= push_idx;
  end

  assign top_idx = empty ? IDX_W'(IDLE) : stk[cnt_m1[PTR_W-1:0]];

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CNT_W'(DEPTH)));  // R9
  AST_PUSH_STRICT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (push && !empty) |-> (push_idx < top_idx));  // R9
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_INT = 8,
  parameter int ADDR_W  = 14,
  parameter int NUM_SRC = 1 + NUM_PINS + NUM_INT,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rst_req,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic [NUM_PINS-1:0] edge_sel,
  input  logic [NUM_INT-1:0]  int_req,
  input  logic [NUM_SRC-2:0]  mask,
  input  logic                nest_mode,
  input  logic                ack,
  input  logic                rti,
  output logic                irq_valid,
  output logic [IDX_W-1:0]    vec_idx,
  output logic [ADDR_W-1:0]   vec_addr
);
  localparam int PIN_BASE = 1;
  localparam int INT_BASE = 1 + NUM_PINS;

  logic [NUM_PINS-1:0] pin_pend;
  logic [NUM_PINS-1:0] pin_clr;
  logic [NUM_SRC-1:0]  pend;
  logic [NUM_SRC-1:0]  cand;
  logic                found;
  logic [IDX_W-1:0]    sel_idx;
  logic                accept;
  logic                pop;
  logic                stk_empty;
  logic [IDX_W-1:0]    top_idx;
  logic [NUM_SRC-2:0]  mask_q;

  assign accept = ack & irq_valid;
  assign pop    = rti & ~accept;

  irq_pin_sense #(.NUM_PINS(NUM_PINS)) u_sense (
    .clk(clk), .rst(rst), .pin_n(pin_n), .edge_sel(edge_sel),
    .clr(pin_clr), .pend(pin_pend)
  );

  // highest-numbered pin gets the best pin priority
  assign pend[0] = rst_req;
  for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin_map
    localparam int SRC = PIN_BASE + (NUM_PINS - 1 - j);
    assign pend[SRC]  = pin_pend[j];
    assign pin_clr[j] = accept && (vec_idx == IDX_W'(SRC));
  end
  for (genvar k = 0; k < NUM_INT; k++) begin : g_int_map
    assign pend[INT_BASE + k] = int_req[k];
  end

  // eligibility: reset bypasses mask and mode gate
  assign cand[0] = pend[0] && (top_idx != '0);
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_elig
    logic gate;
    assign gate    = nest_mode ? (IDX_W'(i) < top_idx) : stk_empty;
    assign cand[i] = pend[i] && mask[i-1] && gate;
  end

  irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .found(found), .idx(sel_idx)
  );

  irq_level_stack #(.DEPTH(NUM_SRC), .IDX_W(IDX_W), .IDLE(NUM_SRC)) u_stack (
    .clk(clk), .rst(rst), .push(accept), .push_idx(vec_idx), .pop(pop),
    .empty(stk_empty), .top_idx(top_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      vec_idx   <= '0;
      vec_addr  <= '0;
      mask_q    <= '0;
    end else begin
      irq_valid <= found && !ack && !rti;
      vec_idx   <= sel_idx;
      vec_addr  <= ADDR_W'(sel_idx) << VEC_SHIFT;
      mask_q    <= mask;
    end
  end

  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid) |=> !irq_valid);  // R8
  AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && vec_idx != '0) |-> mask_q[vec_idx - 1'b1]);  // R3
endmodule

// File: tb/irq_vector_ctl_test.sv
`timescale 1ns/1ps
module irq_vector_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_req = 1'b0;
  logic [2:0]  pin_n = 3'b111;
  logic [2:0]  edge_sel = 3'b000;
  logic [7:0]  int_req = '0;
  logic [10:0] mask = '1;
  logic        nest_mode = 1'b1;
  logic        ack = 1'b0;
  logic        rti = 1'b0;
  logic        irq_valid;
  logic [3:0]  vec_idx;
  logic [13:0] vec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_vector_ctl uut (
    .clk(clk), .rst(rst), .rst_req(rst_req), .pin_n(pin_n), .edge_sel(edge_sel),
    .int_req(int_req), .mask(mask), .nest_mode(nest_mode), .ack(ack), .rti(rti),
    .irq_valid(irq_valid), .vec_idx(vec_idx), .vec_addr(vec_addr)
  );

  // {pins_n(3), int_req(8), mask(11), valid(1), idx(4)}
  localparam int NV = 8;
  localparam logic [26:0] TABLE [NV] = '{
    {3'b111, 8'h00, 11'h7FF, 1'b0, 4'd0},
    {3'b111, 8'h80, 11'h7FF, 1'b1, 4'd11},
    {3'b111, 8'h24, 11'h7FF, 1'b1, 4'd6},
    {3'b110, 8'h01, 11'h7FF, 1'b1, 4'd3},
    {3'b010, 8'h00, 11'h7FF, 1'b1, 4'd1},
    {3'b010, 8'h00, 11'h7FE, 1'b1, 4'd3},
    {3'b000, 8'hFF, 11'h000, 1'b0, 4'd0},
    {3'b111, 8'h18, 11'h7BF, 1'b1, 4'd8}
  };

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0; settle();
  endtask

  task automatic pulse_rti();
    rti = 1'b1; @(negedge clk); rti = 1'b0; settle();
  endtask

  task automatic chk(input string tag, input logic v_exp, input logic [3:0] i_exp);
    checks++;
    if (irq_valid !== v_exp ||
        (v_exp && (vec_idx !== i_exp || vec_addr !== {8'd0, i_exp, 2'b00}))) begin
      fails++;
      $display("FAIL %s: valid=%0b idx=%0d addr=%0d, expected valid=%0b idx=%0d addr=%0d",
               tag, irq_valid, vec_idx, vec_addr, v_exp, i_exp, i_exp * 4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (irq_valid !== 1'b0 || vec_idx !== 4'd0 || vec_addr !== 14'd0) begin
      fails++;
      $display("FAIL R1: valid=%0b idx=%0d addr=%0d, expected 0 0 0", irq_valid, vec_idx, vec_addr);
    end

    // table walk: level mode, idle service state (R2, R3, R5, R6)
    for (int n = 0; n < NV; n++) begin
      {pin_n, int_req, mask} = TABLE[n][26:5];
      settle();
      chk($sformatf("R2/R3 vector %0d", n), TABLE[n][4], TABLE[n][3:0]);
    end
    pin_n = 3'b111; int_req = '0; mask = '1; settle();

    // R6: level pin pulse forgotten
    pin_n[0] = 1'b0; @(negedge clk); pin_n[0] = 1'b1; settle();
    chk("R6 level release", 1'b0, 4'd0);

    // R7: edge pin pulse latched until acknowledged
    edge_sel[0] = 1'b1;
    pin_n[0] = 1'b0; @(negedge clk); pin_n[0] = 1'b1; settle();
    chk("R7 edge latched", 1'b1, 4'd3);
    pulse_ack();
    chk("R7 nothing after ack", 1'b0, 4'd0);
    pulse_rti();
    chk("R7 latch cleared by ack", 1'b0, 4'd0);
    edge_sel = '0;

    // R9: nested preemption
    nest_mode = 1'b1;
    int_req[4] = 1'b1; settle();
    chk("R9 first", 1'b1, 4'd8);
    pulse_ack();
    int_req[6] = 1'b1; settle();
    chk("R9 lower refused", 1'b0, 4'd0);
    int_req[0] = 1'b1; settle();
    chk("R9 higher preempts", 1'b1, 4'd4);
    pulse_ack();
    int_req[0] = 1'b0; settle();
    chk("R9 inside level 4", 1'b0, 4'd0);
    pulse_rti();
    chk("R9 back at level 8", 1'b0, 4'd0);
    int_req[4] = 1'b0; pulse_rti();
    chk("R9 stack empty", 1'b1, 4'd10);
    pulse_ack(); int_req[6] = 1'b0; pulse_rti();

    // R10: sequential mode
    nest_mode = 1'b0;
    int_req[5] = 1'b1; settle();
    chk("R10 first", 1'b1, 4'd9);
    pulse_ack(); int_req[5] = 1'b0;
    int_req[0] = 1'b1; settle();
    chk("R10 higher blocked", 1'b0, 4'd0);
    pulse_rti();
    chk("R10 after return", 1'b1, 4'd4);
    pulse_ack(); int_req[0] = 1'b0; pulse_rti();

    // R4: reset request non-maskable and taken during a service
    int_req[1] = 1'b1; settle(); pulse_ack();
    rst_req = 1'b1; settle();
    chk("R4 over active service", 1'b1, 4'd0);
    mask = '0; settle();
    chk("R4 masked", 1'b1, 4'd0);
    pulse_ack();
    chk("R4 not retaken", 1'b0, 4'd0);
    rst_req = 1'b0; int_req[1] = 1'b0;
    pulse_rti(); pulse_rti(); mask = '1;

    // R8 / R11: stray ack and rti change nothing
    pulse_ack();
    pulse_rti();
    nest_mode = 1'b1;
    int_req[7] = 1'b1; settle();
    chk("R8/R11 stray handshakes ignored", 1'b1, 4'd11);
    pulse_ack();
    chk("R8 drop after ack", 1'b0, 4'd0);
    int_req[7] = 1'b0; pulse_rti();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule